// File: doc/BRIEF.md
# Lane Jitter Test Pattern Generator

This block drives a set of serial lanes, one bit per lane per clock, and can replace the normal lane traffic with one of three fixed repeating bit patterns used to stress the clock recovery of a link partner. The patterns are an alternating high-frequency sequence, a low-frequency sequence of five ones followed by five zeros, and a 20-bit mixed-frequency sequence. Every lane carries the same pattern bit in the same cycle.

A 2-bit select input chooses the pattern, and a separate enable input switches the lanes from pass-through to pattern output. Whenever either control changes, the chosen pattern restarts from its first bit. Encoding to a line code and any register access belong to the surrounding logic. All outputs are registered, so every result appears one clock after the inputs that caused it are sampled.

Top module: `jitter_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `lane_out` becomes all zeros after that edge.
- R2: While the pattern is enabled, every bit of `lane_out` carries the same value, whatever `lane_in` holds.
- R3: Select code 2'b00 produces the 10-bit sequence 1010101010 repeated, with the leftmost bit sent first.
- R4: Select code 2'b01 produces the 10-bit sequence 1111100000 repeated, with the leftmost bit sent first.
- R5: Select code 2'b10 produces the 20-bit sequence 11111010110000010100 repeated, with the leftmost bit sent first.
- R6: Select code 2'b11 is reserved and produces the same output as code 2'b00.
- R7: While `pat_en` is 0, each bit of `lane_out` equals the matching bit of `lane_in` sampled at the previous rising edge.
- R8: When the sampled value of `pat_en` or `pat_sel` differs from its value at the previous edge (and after reset), the output after that edge is the first bit of the selected pattern, and the sequence continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pat_en | input | 1 | 1 sends the selected pattern, 0 passes lane data through |
| pat_sel | input | 2 | Pattern code: 00 high, 01 low, 10 mixed, 11 reserved (as 00) |
| lane_in | input | LANES | Normal lane data, one bit per lane |
| lane_out | output | LANES | Registered lane output, one bit per lane |

## Verification
Each of the four select codes is held long enough for at least two full periods, so the 10-bit and 20-bit sequences are told apart by period and content, and the reserved code is told apart from a copy of the low or mixed pattern. Random lane data runs throughout, which separates true pass-through when disabled from pattern output that ignores the lanes. Select changes in mid-pattern, a one-cycle enable drop, and a reset while enabled show whether the sequence restarts at its first bit or wrongly carries its old position along.

// File: rtl/jtp_pkg.sv
package jtp_pkg;

  localparam int unsigned SHORT_LEN = 10;
  localparam int unsigned LONG_LEN  = 20;
  localparam int unsigned POS_W     = $clog2(LONG_LEN);

  typedef enum logic [1:0] {
    SEL_HIGH  = 2'b00,
    SEL_LOW   = 2'b01,
    SEL_MIXED = 2'b10,
    SEL_RSVD  = 2'b11
  } pat_sel_t;

  // Leftmost written bit is the MSB and is sent first.
  localparam logic [SHORT_LEN-1:0] HIGH_BITS  = 10'b1010101010;
  localparam logic [SHORT_LEN-1:0] LOW_BITS   = 10'b1111100000;
  localparam logic [LONG_LEN-1:0]  MIXED_BITS = 20'b11111010110000010100;

  function automatic logic [POS_W-1:0] last_pos(input logic [1:0] sel);
    if (sel == SEL_MIXED) return POS_W'(LONG_LEN - 1);
    return POS_W'(SHORT_LEN - 1);
  endfunction

  function automatic logic pick_bit(input logic [1:0] sel, input logic [POS_W-1:0] pos);
    int unsigned p;
    p = int'(pos);
    case (sel)
      SEL_LOW:   return LOW_BITS[SHORT_LEN-1-p];
      SEL_MIXED: return MIXED_BITS[LONG_LEN-1-p];
      default:   return HIGH_BITS[SHORT_LEN-1-p];
    endcase
  endfunction

endpackage

// File: rtl/jtp_phase.sv
module jtp_phase
  import jtp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       bit_o
);

  logic             en_q;
  logic [1:0]       sel_q;
  logic [POS_W-1:0] pos_q;
  logic             cfg_chg;
  logic [POS_W-1:0] idx;

  assign cfg_chg = (en != en_q) || (sel != sel_q);
  assign idx     = cfg_chg ? '0 : pos_q;
  assign bit_o   = pick_bit(sel, idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= SEL_HIGH;
      pos_q <= '0;
    end else begin
      en_q  <= en;
      sel_q <= sel;
      pos_q <= (idx == last_pos(sel)) ? '0 : idx + 1'b1;
    end
  end

  // R8: a control change restarts the sequence, so the next position is 1
  assert_restart_pos_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> (pos_q == POS_W'(1)));

  // R5: position stays inside the length of the pattern in use
  assert_pos_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    pos_q <= last_pos(sel_q));

endmodule

// File: rtl/jtp_lane_out.sv
module jtp_lane_out #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pat_bit,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] lane_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)     lane_out[g] <= 1'b0;
      else if (en) lane_out[g] <= pat_bit;
      else         lane_out[g] <= lane_in[g];
    end
  end

  // R2: pattern mode drives all lanes alike
  assert_lanes_alike_R2: assert property (@(posedge clk)
    (!rst && en) |=> (lane_out == '0 || lane_out == '1));

  // R7: pass-through copies the sampled lane data
  assert_passthru_R7: assert property (@(posedge clk)
    (!rst && !en) |=> (lane_out == $past(lane_in)));

  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (lane_out == '0));

endmodule

// File: rtl/jitter_pattern_gen.sv
module jitter_pattern_gen #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pat_en,
  input  logic [1:0]       pat_sel,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] lane_out
);

  logic pat_bit;

  jtp_phase i_phase (
    .clk   (clk),
    .rst   (rst),
    .en    (pat_en),
    .sel   (pat_sel),
    .bit_o (pat_bit)
  );

  jtp_lane_out #(.LANES(LANES)) i_lanes (
    .clk      (clk),
    .rst      (rst),
    .en       (pat_en),
    .pat_bit  (pat_bit),
    .lane_in  (lane_in),
    .lane_out (lane_out)
  );

endmodule

// File: tb/test_jitter_pattern_gen.sv
module test_jitter_pattern_gen;

  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pat_en = 1'b0;
  logic [1:0]       pat_sel = 2'b00;
  logic [LANES-1:0] lane_in = '0;
  logic [LANES-1:0] lane_out;

  jitter_pattern_gen #(.LANES(LANES)) i_jitter_pattern_gen (
    .clk(clk), .rst(rst), .pat_en(pat_en), .pat_sel(pat_sel),
    .lane_in(lane_in), .lane_out(lane_out)
  );

  always #5 clk = ~clk;

  // Reference model: patterns as text, sent left to right
  string  pats [4] = '{"1010101010", "1111100000", "11111010110000010100", "1010101010"};
  logic [LANES-1:0] exp_out = '0;
  logic   exp_en = 1'b0;
  string  tag = "R1";
  int     m_pos = 0;
  logic   m_en = 1'b0;
  logic [1:0] m_sel = 2'b00;
  bit     started = 1'b0;
  int     checks = 0;
  int     fails = 0;
  int     cycles = 0;
  bit     done = 1'b0;

  always @(posedge clk) begin
    bit restart;
    started = 1'b1;
    cycles++;
    if (rst) begin
      exp_out = '0; exp_en = 1'b0; tag = "R1";
      m_pos = 0; m_en = 1'b0; m_sel = 2'b00;
    end else begin
      restart = (pat_en != m_en) || (pat_sel != m_sel);
      if (restart) m_pos = 0;
      exp_en = pat_en;
      if (pat_en) begin
        exp_out = {LANES{pats[pat_sel][m_pos] == "1"}};
        if (restart)              tag = "R8";
        else if (pat_sel == 2'b00) tag = "R3";
        else if (pat_sel == 2'b01) tag = "R4";
        else if (pat_sel == 2'b10) tag = "R5";
        else                       tag = "R6";
      end else begin
        exp_out = lane_in;
        tag = "R7";
      end
      m_pos = (m_pos + 1) % pats[pat_sel].len();
      m_en = pat_en; m_sel = pat_sel;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (lane_out !== exp_out) begin
        fails++;
        $display("FAIL %s: lane_out=%b expected %b (t=%0t)", tag, lane_out, exp_out, $time);
      end
      if (exp_en) begin
        checks++;
        if (lane_out != '0 && lane_out != '1) begin
          fails++;
          $display("FAIL R2: lane_out=%b expected all lanes alike", lane_out);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic run(input int n, input logic en, input logic [1:0] sel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      pat_en = en; pat_sel = sel;
      lane_in = LANES'($urandom);
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected < 5000", cycles);
      finish_run();
    end
  end

  initial begin
    run(3, 1'b0, 2'b00);          // R1 reset state
    @(negedge clk); #1 rst = 1'b0;
    run(20, 1'b0, 2'b01);         // R7 pass-through
    run(25, 1'b1, 2'b00);         // R3
    run(25, 1'b1, 2'b01);         // R4
    run(45, 1'b1, 2'b10);         // R5
    run(25, 1'b1, 2'b11);         // R6
    run(7, 1'b1, 2'b00);          // R8 mid-pattern change
    run(13, 1'b1, 2'b10);
    run(3, 1'b1, 2'b01);
    run(1, 1'b0, 2'b01);          // one-cycle enable drop
    run(14, 1'b1, 2'b01);
    run(6, 1'b1, 2'b10);
    @(negedge clk); #1 rst = 1'b1;  // reset while enabled
    run(2, 1'b1, 2'b10);
    @(negedge clk); #1 rst = 1'b0;
    run(25, 1'b1, 2'b10);
    run(10, 1'b0, 2'b10);
    run(2, 1'b0, 2'b10);
    finish_run();
  end

endmodule